// File: doc/BRIEF.md
# Machine Trap CSR File with Privilege Check

This block holds the machine-level trap registers of a small core together with three free-running counters. Software reaches it through one combinational swap port. The core presents a request, a 12-bit register number, write data, a write enable and the current privilege mode. In the same cycle it gets back the previous contents of the register and a flag that says whether the access is illegal. A legal write takes effect at the next clock edge.

The required privilege of each register comes straight from address bits [9:8]. User code may only reach level 0. A write to the read-only counter window is refused. Unknown addresses read as zero and are refused.

A trap controller has its own side ports. It loads the exception PC, the cause and the status word, and these loads win over a software write in the same cycle. It reads the trap vector, the exception PC and the status word without using the software port.

Top module: `mcsr_file`

## Requirements
- R1: After reset the trap vector holds TVEC_RESET (default 0x0000_0100). Status, interrupt enable, scratch, exception PC, cause, trap value, interrupt pending and all three counters hold zero.
- R2: Address bits [9:8] give the required level (0 user, 1 supervisor, 2 hypervisor, 3 machine). With privMode=0 (user), an access to any address with a nonzero level sets csrIllegal, returns zero and changes no register. privMode=1 (machine) may use every level.
- R3: A legal access returns the register's previous value on csrRdata in the same cycle. When csrWe is set, csrWdata is stored at the next rising clock edge.
- R4: The implemented registers are: 0x300 status, 0x301 ISA, 0x304 interrupt enable, 0x305 trap vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0x343 trap value and 0x344 interrupt pending. ISA always reads ISA_VALUE (default 0x4000_1100). A write to ISA is legal but has no effect.
- R5: The counters at 0xC00 (cycle), 0xC01 (time) and 0xC02 (retired) are read-only. A write there raises csrIllegal, returns zero and does not disturb counting. A read is legal in either mode.
- R6: The cycle counter adds one on every clock edge out of reset. The time counter adds one on each edge where timeTick is high. The retired counter adds one on each edge where retireStrobe is high.
- R7: Only status bits 3 (interrupt enable) and 7 (previous enable) are stored. Writing all ones reads back 0x88.
- R8: The two low bits of the exception PC always read zero, for both software and hardware loads.
- R9: An access to an address that is not listed in R4 or R5 raises csrIllegal and reads zero.
- R10: When hwEpcWe, hwCauseWe or hwStatusWe is high, the hardware value is stored, even if a software write to the same register happens in that cycle.
- R11: trapVector, excPc and statusOut always show the current trap vector, exception PC and status.
- R12: With csrReq low, csrRdata and csrIllegal are zero and no software write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrReq | input | 1 | Software access valid |
| csrAddr | input | 12 | Register number |
| csrWe | input | 1 | Swap writes new value |
| csrWdata | input | XLEN | Value to write |
| privMode | input | 1 | 0 user, 1 machine |
| csrRdata | output | XLEN | Previous register value |
| csrIllegal | output | 1 | Access refused |
| hwEpcWe | input | 1 | Trap side loads exception PC |
| hwEpc | input | XLEN | Exception PC from trap side |
| hwCauseWe | input | 1 | Trap side loads cause |
| hwCause | input | XLEN | Cause from trap side |
| hwStatusWe | input | 1 | Trap side loads status |
| hwStatus | input | XLEN | Status from trap side |
| timeTick | input | 1 | Time counter increment |
| retireStrobe | input | 1 | Instruction retired |
| trapVector | output | XLEN | Current trap vector |
| excPc | output | XLEN | Current exception PC |
| statusOut | output | XLEN | Current status |

## Verification
The assertions assume that csrAddr, csrWe and privMode hold steady for the whole cycle in which csrReq is high, and that the trap-side loads are single-cycle pulses sampled at the clock edge. The stimulus changes every input only at the falling edge and holds it through the next rising edge. It mixes machine and user accesses, read-only window writes, unknown addresses and trap loads that collide with software writes to the same register. A behavioural model in the bench predicts every register and counter, and the design is compared with it each cycle.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_STATUS, SEL_ISA, SEL_IE, SEL_TVEC, SEL_SCRATCH,
    SEL_EPC, SEL_CAUSE, SEL_TVAL, SEL_IP, SEL_CYCLE, SEL_TIME, SEL_INSTRET
  } csrSel_e;

  typedef struct packed {
    csrSel_e sel;
    logic    doWrite;
    logic    illegal;
  } csrStrobe_t;

  localparam logic [11:0] ADDR_STATUS  = 12'h300;
  localparam logic [11:0] ADDR_ISA     = 12'h301;
  localparam logic [11:0] ADDR_IE      = 12'h304;
  localparam logic [11:0] ADDR_TVEC    = 12'h305;
  localparam logic [11:0] ADDR_SCRATCH = 12'h340;
  localparam logic [11:0] ADDR_EPC     = 12'h341;
  localparam logic [11:0] ADDR_CAUSE   = 12'h342;
  localparam logic [11:0] ADDR_TVAL    = 12'h343;
  localparam logic [11:0] ADDR_IP      = 12'h344;
  localparam logic [11:0] ADDR_CYCLE   = 12'hC00;
  localparam logic [11:0] ADDR_TIME    = 12'hC01;
  localparam logic [11:0] ADDR_INSTRET = 12'hC02;

  localparam int NUM_CNT = 3;
endpackage

// File: rtl/mcsr_ctrl.sv
module mcsr_ctrl
  import mcsr_pkg::*;
(
  input  logic        csrReq,
  input  logic [11:0] csrAddr,
  input  logic        csrWe,
  input  logic        privMode,
  output csrStrobe_t  strobe
);
  csrSel_e decSel;
  logic    levelFault;
  logic    roFault;
  logic    unimpl;
  logic    anyFault;

  always_comb begin
    unique case (csrAddr)
      ADDR_STATUS:  decSel = SEL_STATUS;
      ADDR_ISA:     decSel = SEL_ISA;
      ADDR_IE:      decSel = SEL_IE;
      ADDR_TVEC:    decSel = SEL_TVEC;
      ADDR_SCRATCH: decSel = SEL_SCRATCH;
      ADDR_EPC:     decSel = SEL_EPC;
      ADDR_CAUSE:   decSel = SEL_CAUSE;
      ADDR_TVAL:    decSel = SEL_TVAL;
      ADDR_IP:      decSel = SEL_IP;
      ADDR_CYCLE:   decSel = SEL_CYCLE;
      ADDR_TIME:    decSel = SEL_TIME;
      ADDR_INSTRET: decSel = SEL_INSTRET;
      default:      decSel = SEL_NONE;
    endcase
  end

  // level field in bits [9:8]; user may only reach level 0
  assign levelFault = !privMode && (csrAddr[9:8] != 2'b00);
  // top two address bits both set marks the read-only space
  assign roFault    = csrWe && (csrAddr[11:10] == 2'b11);
  assign unimpl     = (decSel == SEL_NONE);
  assign anyFault   = levelFault || roFault || unimpl;

  always_comb begin
    strobe.illegal = csrReq && anyFault;
    strobe.doWrite = csrReq && csrWe && !anyFault;
    strobe.sel     = (csrReq && !anyFault) ? decSel : SEL_NONE;
  end
endmodule

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rstN)    value <= '0;
    else if (inc) value <= value + 1'b1;
  end
endmodule

// File: rtl/mcsr_dp.sv
module mcsr_dp
  import mcsr_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] ISA_VALUE  = 32'h4000_1100,
  parameter logic [XLEN-1:0] TVEC_RESET = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rstN,
  input  csrStrobe_t      strobe,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  input  logic            hwEpcWe,
  input  logic [XLEN-1:0] hwEpc,
  input  logic            hwCauseWe,
  input  logic [XLEN-1:0] hwCause,
  input  logic            hwStatusWe,
  input  logic [XLEN-1:0] hwStatus,
  input  logic            timeTick,
  input  logic            retireStrobe,
  output logic [XLEN-1:0] trapVector,
  output logic [XLEN-1:0] excPc,
  output logic [XLEN-1:0] statusOut
);
  localparam logic [XLEN-1:0] STATUS_MASK = XLEN'(8'h88);
  localparam logic [XLEN-1:0] EPC_MASK    = ~XLEN'(3);

  logic [XLEN-1:0] statusReg, ieReg, tvecReg, scratchReg;
  logic [XLEN-1:0] epcReg, causeReg, tvalReg, ipReg;
  logic [XLEN-1:0] cntVal [NUM_CNT];
  logic [NUM_CNT-1:0] cntInc;

  function automatic logic swWr(input csrStrobe_t s, input csrSel_e target);
    return s.doWrite && (s.sel == target);
  endfunction

  assign cntInc = {retireStrobe, timeTick, 1'b1};

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    mcsr_counter #(.W(XLEN)) uCnt (
      .clk  (clk),
      .rstN (rstN),
      .inc  (cntInc[g]),
      .value(cntVal[g])
    );
  end

  // hardware-side loads take precedence over the software port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      epcReg    <= '0;
      causeReg  <= '0;
    end else begin
      if (hwStatusWe)                   statusReg <= hwStatus & STATUS_MASK;
      else if (swWr(strobe, SEL_STATUS)) statusReg <= csrWdata & STATUS_MASK;
      if (hwEpcWe)                      epcReg <= hwEpc & EPC_MASK;
      else if (swWr(strobe, SEL_EPC))   epcReg <= csrWdata & EPC_MASK;
      if (hwCauseWe)                    causeReg <= hwCause;
      else if (swWr(strobe, SEL_CAUSE)) causeReg <= csrWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieReg      <= '0;
      tvecReg    <= TVEC_RESET;
      scratchReg <= '0;
      tvalReg    <= '0;
      ipReg      <= '0;
    end else begin
      if (swWr(strobe, SEL_IE))      ieReg      <= csrWdata;
      if (swWr(strobe, SEL_TVEC))    tvecReg    <= csrWdata;
      if (swWr(strobe, SEL_SCRATCH)) scratchReg <= csrWdata;
      if (swWr(strobe, SEL_TVAL))    tvalReg    <= csrWdata;
      if (swWr(strobe, SEL_IP))      ipReg      <= csrWdata;
    end
  end

  always_comb begin
    unique case (strobe.sel)
      SEL_STATUS:  csrRdata = statusReg;
      SEL_ISA:     csrRdata = ISA_VALUE;
      SEL_IE:      csrRdata = ieReg;
      SEL_TVEC:    csrRdata = tvecReg;
      SEL_SCRATCH: csrRdata = scratchReg;
      SEL_EPC:     csrRdata = epcReg;
      SEL_CAUSE:   csrRdata = causeReg;
      SEL_TVAL:    csrRdata = tvalReg;
      SEL_IP:      csrRdata = ipReg;
      SEL_CYCLE:   csrRdata = cntVal[0];
      SEL_TIME:    csrRdata = cntVal[1];
      SEL_INSTRET: csrRdata = cntVal[2];
      default:     csrRdata = '0;
    endcase
  end

  assign trapVector = tvecReg;
  assign excPc      = epcReg;
  assign statusOut  = statusReg;
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] ISA_VALUE  = 32'h4000_1100,
  parameter logic [XLEN-1:0] TVEC_RESET = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrReq,
  input  logic [11:0]     csrAddr,
  input  logic            csrWe,
  input  logic [XLEN-1:0] csrWdata,
  input  logic            privMode,
  output logic [XLEN-1:0] csrRdata,
  output logic            csrIllegal,
  input  logic            hwEpcWe,
  input  logic [XLEN-1:0] hwEpc,
  input  logic            hwCauseWe,
  input  logic [XLEN-1:0] hwCause,
  input  logic            hwStatusWe,
  input  logic [XLEN-1:0] hwStatus,
  input  logic            timeTick,
  input  logic            retireStrobe,
  output logic [XLEN-1:0] trapVector,
  output logic [XLEN-1:0] excPc,
  output logic [XLEN-1:0] statusOut
);
  csrStrobe_t strobe;

  mcsr_ctrl uCtrl (
    .csrReq  (csrReq),
    .csrAddr (csrAddr),
    .csrWe   (csrWe),
    .privMode(privMode),
    .strobe  (strobe)
  );

  mcsr_dp #(
    .XLEN      (XLEN),
    .ISA_VALUE (ISA_VALUE),
    .TVEC_RESET(TVEC_RESET)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .csrWdata    (csrWdata),
    .csrRdata    (csrRdata),
    .hwEpcWe     (hwEpcWe),
    .hwEpc       (hwEpc),
    .hwCauseWe   (hwCauseWe),
    .hwCause     (hwCause),
    .hwStatusWe  (hwStatusWe),
    .hwStatus    (hwStatus),
    .timeTick    (timeTick),
    .retireStrobe(retireStrobe),
    .trapVector  (trapVector),
    .excPc       (excPc),
    .statusOut   (statusOut)
  );

  assign csrIllegal = strobe.illegal;
endmodule

// File: rtl/mcsr_file_chk.sv
module mcsr_file_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrReq,
  input logic [11:0]     csrAddr,
  input logic            csrWe,
  input logic            privMode,
  input logic [XLEN-1:0] csrRdata,
  input logic            csrIllegal,
  input logic            hwEpcWe,
  input logic [XLEN-1:0] hwEpc,
  input logic            hwStatusWe,
  input logic [XLEN-1:0] hwStatus,
  input logic [XLEN-1:0] trapVector,
  input logic [XLEN-1:0] excPc,
  input logic [XLEN-1:0] statusOut
);
  localparam logic [XLEN-1:0] LOW2 = XLEN'(3);
  localparam logic [XLEN-1:0] SMASK = XLEN'(8'h88);

  a_r2_user_level: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && !privMode && csrAddr[9:8] != 2'b00) |-> csrIllegal);

  a_r5_ro_write: assert property (@(posedge clk) disable iff (!rstN)
    (csrReq && csrWe && csrAddr[11:10] == 2'b11) |-> csrIllegal);

  a_r9_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> (csrRdata == '0));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !csrReq |-> (!csrIllegal && csrRdata == '0));

  a_r8_epc_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (excPc & LOW2) == '0);

  a_r7_status_bits: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut & ~SMASK) == '0);

  a_r10_epc_priority: assert property (@(posedge clk) disable iff (!rstN)
    hwEpcWe |=> (excPc == ($past(hwEpc) & ~LOW2)));

  a_r10_status_priority: assert property (@(posedge clk) disable iff (!rstN)
    hwStatusWe |=> (statusOut == ($past(hwStatus) & SMASK)));

  a_r11_tvec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(csrReq && csrWe && !csrIllegal && csrAddr == 12'h305) |=> $stable(trapVector));
endmodule

bind mcsr_file mcsr_file_chk #(.XLEN(XLEN)) uChk (.*);

// File: tb/mcsr_file_test.sv
module mcsr_file_test;
  localparam int XLEN = 32;
  localparam logic [31:0] ISA_V  = 32'h4000_1100;
  localparam logic [31:0] TVEC_R = 32'h0000_0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrReq = 0, csrWe = 0, privMode = 0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic csrIllegal;
  logic hwEpcWe = 0, hwCauseWe = 0, hwStatusWe = 0;
  logic [31:0] hwEpc = '0, hwCause = '0, hwStatus = '0;
  logic timeTick = 0, retireStrobe = 0;
  logic [31:0] trapVector, excPc, statusOut;

  int checks = 0;
  int fails = 0;

  // behavioural model state
  logic [31:0] mStatus, mIe, mTvec, mScratch, mEpc, mCause, mTval, mIp;
  logic [31:0] mCyc, mTim, mRet;

  always #2.5 clk = ~clk;

  mcsr_file #(.XLEN(XLEN)) uut (.*);

  function automatic logic isImpl(input logic [11:0] a);
    case (a)
      12'h300, 12'h301, 12'h304, 12'h305, 12'h340, 12'h341, 12'h342,
      12'h343, 12'h344, 12'hC00, 12'hC01, 12'hC02: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic expIll(input logic rq, input logic [11:0] a,
                                  input logic w, input logic md);
    if (!rq) return 1'b0;
    return (!md && a[9:8] != 0) || (w && a[11:10] == 2'b11) || !isImpl(a);
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a)
      12'h300: return mStatus;
      12'h301: return ISA_V;
      12'h304: return mIe;
      12'h305: return mTvec;
      12'h340: return mScratch;
      12'h341: return mEpc;
      12'h342: return mCause;
      12'h343: return mTval;
      12'h344: return mIp;
      12'hC00: return mCyc;
      12'hC01: return mTim;
      12'hC02: return mRet;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, compare combinational outputs, advance model at the edge
  task automatic step(input string tag, input logic rq, input logic [11:0] a,
                      input logic w, input logic [31:0] wd, input logic md);
    logic ill;
    logic [31:0] expRd;
    csrReq = rq; csrAddr = a; csrWe = w; csrWdata = wd; privMode = md;
    #1;
    ill   = expIll(rq, a, w, md);
    expRd = (rq && !ill) ? modelRead(a) : 32'h0;
    check(tag, "rdata", csrRdata, expRd);
    check(tag, "illegal", {31'h0, csrIllegal}, {31'h0, ill});
    check("R11", "trapVector", trapVector, mTvec);
    check("R11", "excPc", excPc, mEpc);
    check("R11", "statusOut", statusOut, mStatus);
    @(posedge clk);
    if (rq && w && !ill) begin
      case (a)
        12'h300: mStatus  = wd & 32'h88;
        12'h304: mIe      = wd;
        12'h305: mTvec    = wd;
        12'h340: mScratch = wd;
        12'h341: mEpc     = wd & ~32'h3;
        12'h342: mCause   = wd;
        12'h343: mTval    = wd;
        12'h344: mIp      = wd;
        default: ;
      endcase
    end
    if (hwEpcWe)    mEpc    = hwEpc & ~32'h3;
    if (hwCauseWe)  mCause  = hwCause;
    if (hwStatusWe) mStatus = hwStatus & 32'h88;
    mCyc = mCyc + 1;
    if (timeTick)     mTim = mTim + 1;
    if (retireStrobe) mRet = mRet + 1;
    @(negedge clk);
    hwEpcWe = 0; hwCauseWe = 0; hwStatusWe = 0;
    timeTick = 0; retireStrobe = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mStatus = 0; mIe = 0; mTvec = TVEC_R; mScratch = 0; mEpc = 0;
    mCause = 0; mTval = 0; mIp = 0; mCyc = 0; mTim = 0; mRet = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values through machine-mode reads
    step("R1", 1, 12'h305, 0, 0, 1);
    step("R1", 1, 12'h300, 0, 0, 1);
    step("R1", 1, 12'h341, 0, 0, 1);
    step("R1", 1, 12'hC01, 0, 0, 1);
    step("R1", 1, 12'hC02, 0, 0, 1);
    // R12 idle port
    step("R12", 0, 12'h340, 1, 32'hDEAD_BEEF, 1);
    step("R12", 1, 12'h340, 0, 0, 1);
    // R3 swap
    step("R3", 1, 12'h340, 1, 32'h1234_5678, 1);
    step("R3", 1, 12'h340, 1, 32'h9ABC_DEF0, 1);
    step("R3", 1, 12'h340, 0, 0, 1);
    step("R3", 1, 12'h343, 1, 32'h0000_00AA, 1);
    step("R3", 1, 12'h344, 1, 32'h0000_0880, 1);
    step("R3", 1, 12'h304, 1, 32'h0000_0888, 1);
    step("R3", 1, 12'h304, 0, 0, 1);
    // R7 status masking
    step("R7", 1, 12'h300, 1, 32'hFFFF_FFFF, 1);
    step("R7", 1, 12'h300, 1, 32'h0000_0008, 1);
    step("R7", 1, 12'h300, 0, 0, 1);
    // R8 exception PC alignment
    step("R8", 1, 12'h341, 1, 32'h0000_1003, 1);
    step("R8", 1, 12'h341, 0, 0, 1);
    // R4 ISA constant, trap vector
    step("R4", 1, 12'h301, 1, 32'hFFFF_FFFF, 1);
    step("R4", 1, 12'h301, 0, 0, 1);
    step("R4", 1, 12'h305, 1, 32'h8000_0040, 1);
    step("R11", 1, 12'h305, 0, 0, 1);
    // R2 user-mode level check
    step("R2", 1, 12'h340, 1, 32'h5555_5555, 0);
    step("R2", 1, 12'h340, 0, 0, 1);
    step("R2", 1, 12'h300, 0, 0, 0);
    step("R2", 1, 12'h305, 1, 32'h0, 0);
    step("R2", 1, 12'h100, 0, 0, 0);
    step("R2", 1, 12'hC00, 0, 0, 0);
    // R9 unknown addresses
    step("R9", 1, 12'h100, 0, 0, 1);
    step("R9", 1, 12'h7C0, 1, 32'h1, 1);
    step("R9", 1, 12'h0FF, 0, 0, 0);
    step("R9", 1, 12'hC03, 0, 0, 1);
    // R6 counters with tick / retire patterns
    for (int i = 0; i < 12; i++) begin
      timeTick = (i % 3 == 0);
      retireStrobe = (i % 2 == 1);
      step("R6", 1, (i % 2) ? 12'hC01 : 12'hC02, 0, 0, 1);
    end
    step("R6", 1, 12'hC00, 0, 0, 1);
    // R5 read-only counter writes
    timeTick = 1;
    step("R5", 1, 12'hC01, 1, 32'h0, 1);
    step("R5", 1, 12'hC01, 0, 0, 1);
    retireStrobe = 1;
    step("R5", 1, 12'hC02, 1, 32'hFFFF_FFFF, 1);
    step("R5", 1, 12'hC00, 1, 32'h0, 0);
    step("R5", 1, 12'hC02, 0, 0, 0);
    // R10 hardware loads versus colliding software writes
    hwEpcWe = 1; hwEpc = 32'h0040_0013;
    step("R10", 1, 12'h341, 1, 32'h0000_2000, 1);
    step("R10", 1, 12'h341, 0, 0, 1);
    hwCauseWe = 1; hwCause = 32'h0000_0008;
    step("R10", 1, 12'h342, 1, 32'h0000_000B, 1);
    step("R10", 1, 12'h342, 0, 0, 1);
    hwStatusWe = 1; hwStatus = 32'h0000_0080;
    step("R10", 1, 12'h300, 1, 32'h0000_0088, 1);
    step("R10", 1, 12'h300, 0, 0, 1);
    hwEpcWe = 1; hwEpc = 32'h0000_0FFC;
    step("R10", 1, 12'h340, 1, 32'h0000_0777, 1);
    step("R10", 1, 12'h341, 0, 0, 1);
    step("R10", 1, 12'h340, 0, 0, 1);
    // software write to cause without a colliding load
    step("R3", 1, 12'h342, 1, 32'h0000_000B, 1);
    step("R3", 1, 12'h342, 0, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule